// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a free-running watchdog timer. A slow tick strobe drives it through a programmable prescaler into a 12-bit down-counter. Software sees a small 32-bit register port. One control register accepts 16-bit command keys: one key starts the counter, one refreshes it, and one opens the configuration registers for writing. The configuration registers hold the prescaler code, the reload value and the window value.

When the counter runs out, the block raises a one-cycle reset request. It also raises the request when software refreshes too early, meaning the count is still above a programmed window value. Each configuration register is copied into the running logic only after a short synchronisation delay, counted in ticks. A status register shows which copies are still pending. Once started, the counter cannot be stopped except by system reset.

Top module: `keyed_wdog`

## Requirements
- R1: Register offsets are: control 0x00, prescaler 0x04, reload 0x08, status 0x0C and window 0x10. The command key sits in bits 15:0 of a control write. Writing key 0x5555 opens the prescaler, reload and window registers for writing, and they stay open through any number of configuration writes. Any other control value closes them. A configuration write while they are closed changes neither the read-back value nor the status register.
- R2: An accepted configuration write sets its busy flag in the status register from the next cycle. Bit 0 is the prescaler flag, bit 1 the reload flag and bit 2 the window flag. The flag stays set for 3 tick cycles. Until the flag clears, the register still reads back, and acts with, its previous value; the new value reads back and takes effect in the same cycle the flag clears.
- R3: Writing key 0xCCCC starts the counter, loaded with the reload value. Before the start key is written, no reset request is ever raised, even when the refresh key is written.
- R4: The prescaler code selects a divide ratio of 4 << code for codes 0 to 6. Code 7 divides by 256.
- R5: With a tick present every cycle, a reload value R and a divide ratio D, the reset request appears R·D cycles after the clock edge that wrote the start or refresh key. The request lasts exactly one cycle. The counter then reloads and keeps running.
- R6: Writing key 0xAAAA reloads the counter from the reload value and restarts the prescaler phase.
- R7: Once started, the counter keeps running after any control write, including 0x0000.
- R8: While the window value is below 0xFFF, a refresh that arrives while the count is above the window value raises the reset request in the next cycle. A refresh with the count equal to or below the window value raises no request. A window value of 0xFFF turns this check off.
- R9: After reset, the registers read prescaler 0, reload 0xFFF, window 0xFFF and status 0, and the counter is idle. The control register and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous system reset |
| tick_i | input | 1 | Slow-tick enable strobe, one cycle per tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| wdog_req_o | output | 1 | One-cycle reset request |

## Verification
Timeouts are driven with random prescaler codes and reload values, each followed by a refresh. The exact cycle of the request tells a wrong divide ratio from an off-by-one in the count or a prescaler phase that a refresh failed to clear. Directed lock sequences tell a correct close-on-any-other-key from a lock that only closes on 0x0000. Directed refreshes land at counts just above, equal to and below the window value, which finds a window compare using the wrong inequality. An early refresh made while the window is 0xFFF tells apart a check that is really switched off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 16;
    localparam int PSC_W   = 3;
    localparam int CNT_W   = 12;
    localparam int NUM_CFG = 3;

    // status bit / config slot index
    localparam int IDX_PSC = 0;
    localparam int IDX_RLD = 1;
    localparam int IDX_WIN = 2;

    localparam logic [ADDR_W-1:0] OFF_CTL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_PSC  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_RLD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_WIN  = 5'h10;

    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
    import wdg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ctl_wr_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             unlocked_o,
    output logic             running_o,
    output logic             start_o,
    output logic             refresh_o
);
    typedef struct packed {
        logic unlocked;
        logic running;
    } key_st_t;

    key_st_t s_d, s_q;

    assign start_o   = ctl_wr_i && (key_i == KEY_START);
    assign refresh_o = ctl_wr_i && (key_i == KEY_REFRESH);

    always_comb begin
        s_d = s_q;
        if (ctl_wr_i) begin
            s_d.unlocked = (key_i == KEY_UNLOCK);
        end
        if (start_o) begin
            s_d.running = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{unlocked: 1'b0, running: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign unlocked_o = s_q.unlocked;
    assign running_o  = s_q.running;

    // R7
    run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.running |=> s_q.running);

    // R1
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctl_wr_i |=> $stable(s_q.unlocked));
endmodule

// File: rtl/wdg_shadow.sv
module wdg_shadow #(
    parameter int W          = 12,
    parameter bit RST_ONES   = 1'b1,
    parameter int SYNC_TICKS = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] value_o,
    output logic         busy_o
);
    localparam int SC_W = $clog2(SYNC_TICKS + 1);
    localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

    typedef struct packed {
        logic [W-1:0]    pend;
        logic [W-1:0]    act;
        logic            busy;
        logic [SC_W-1:0] scnt;
    } sh_st_t;

    sh_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.pend = wdata_i;
            s_d.busy = 1'b1;
            s_d.scnt = SC_W'(SYNC_TICKS);
        end else if (s_q.busy && tick_i) begin
            if (s_q.scnt <= SC_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.act  = s_q.pend;
                s_d.scnt = '0;
            end else begin
                s_d.scnt = s_q.scnt - SC_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{pend: RST_VAL, act: RST_VAL, busy: 1'b0, scnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign value_o = s_q.act;
    assign busy_o  = s_q.busy;

    // R2
    busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.busy) |-> $past(wr_i));

    // R2
    value_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(s_q.act) |-> $fell(s_q.busy));
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
#(
    parameter int MAX_CODE   = 6,
    parameter int BASE_SHIFT = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             strobe_o
);
    localparam int DIV_W = MAX_CODE + BASE_SHIFT;
    localparam logic [PSC_W-1:0] MAX_C = PSC_W'(MAX_CODE);

    logic [PSC_W-1:0] code_c;
    logic [DIV_W:0]   ratio;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] pdiv_d, pdiv_q;
    logic             wrap;

    always_comb begin
        code_c = (code_i > MAX_C) ? MAX_C : code_i;
        ratio  = {{DIV_W{1'b0}}, 1'b1} << (32'(code_c) + BASE_SHIFT);
        limit  = DIV_W'(ratio - (DIV_W+1)'(1));
        wrap   = (pdiv_q >= limit);
    end

    assign strobe_o = run_i && tick_i && !clr_i && wrap;

    always_comb begin
        pdiv_d = pdiv_q;
        if (!run_i || clr_i) begin
            pdiv_d = '0;
        end else if (tick_i) begin
            pdiv_d = wrap ? '0 : pdiv_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pdiv_q <= '0;
        end else begin
            pdiv_q <= pdiv_d;
        end
    end

    // R4
    idle_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> pdiv_q == '0);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             running_i,
    input  logic             start_i,
    input  logic             refresh_i,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] window_i,
    output logic             req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    win_on, early, expire;

    always_comb begin
        win_on = (window_i != {CNT_W{1'b1}});
        early  = refresh_i && running_i && win_on && (s_q.cnt > window_i);
        expire = strobe_i && (s_q.cnt <= CNT_W'(1));
        s_d     = s_q;
        s_d.req = early || expire;
        if (start_i || refresh_i) begin
            s_d.cnt = reload_i;
        end else if (strobe_i) begin
            s_d.cnt = expire ? reload_i : s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{cnt: '0, req: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o = s_q.req;

    // R3
    req_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.req |-> running_i);

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_i && !start_i && !refresh_i) |=> $stable(s_q.cnt));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdg_pkg::*;
#(
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wdog_req_o
);
    logic               unlocked, running, start, refresh, strobe;
    logic               ctl_wr;
    logic [NUM_CFG-1:0] busy_vec;
    logic [CNT_W-1:0]   cfg_val [NUM_CFG];
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata_i[DATA_W-1:KEY_W];
    assign ctl_wr       = bus_wr_i && (bus_addr_i == OFF_CTL);

    wdg_keydec u_keydec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctl_wr_i   (ctl_wr),
        .key_i      (bus_wdata_i[KEY_W-1:0]),
        .unlocked_o (unlocked),
        .running_o  (running),
        .start_o    (start),
        .refresh_o  (refresh)
    );

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        localparam int W = (gi == IDX_PSC) ? PSC_W : CNT_W;
        localparam logic [ADDR_W-1:0] OFF = (gi == IDX_PSC) ? OFF_PSC :
                                            (gi == IDX_RLD) ? OFF_RLD : OFF_WIN;
        logic [W-1:0] val;
        logic         wr;

        assign wr = bus_wr_i && unlocked && (bus_addr_i == OFF);

        wdg_shadow #(
            .W          (W),
            .RST_ONES   (gi != IDX_PSC),
            .SYNC_TICKS (SYNC_TICKS)
        ) u_shadow (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .tick_i  (tick_i),
            .wr_i    (wr),
            .wdata_i (bus_wdata_i[W-1:0]),
            .value_o (val),
            .busy_o  (busy_vec[gi])
        );

        assign cfg_val[gi] = CNT_W'(val);
    end

    wdg_prescale u_prescale (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (running),
        .clr_i    (start || refresh),
        .tick_i   (tick_i),
        .code_i   (cfg_val[IDX_PSC][PSC_W-1:0]),
        .strobe_o (strobe)
    );

    wdg_counter u_counter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .running_i (running),
        .start_i   (start),
        .refresh_i (refresh),
        .strobe_i  (strobe),
        .reload_i  (cfg_val[IDX_RLD]),
        .window_i  (cfg_val[IDX_WIN]),
        .req_o     (wdog_req_o)
    );

    always_comb begin
        case (bus_addr_i)
            OFF_PSC:  bus_rdata_o = DATA_W'(cfg_val[IDX_PSC]);
            OFF_RLD:  bus_rdata_o = DATA_W'(cfg_val[IDX_RLD]);
            OFF_WIN:  bus_rdata_o = DATA_W'(cfg_val[IDX_WIN]);
            OFF_STAT: bus_rdata_o = DATA_W'(busy_vec);
            default:  bus_rdata_o = '0;
        endcase
    end

    // R1
    locked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == OFF_PSC) && !unlocked) |=> !$rose(busy_vec[IDX_PSC]));
endmodule

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
    logic        clk = 1'b0;
    logic        rst_n, tick, bus_wr, req;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .wdog_req_o  (req)
    );

    function automatic int ratio(input int code);
        return (code > 6) ? 256 : (4 << code);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [4:0] a, input logic [31:0] d);
        wr(5'h00, 32'h5555);
        wr(a, d);
        idle(3);
    endtask

    task automatic wait_req(input int limit, output int at);
        at = -1;
        for (int k = 0; k <= limit; k++) begin
            if (req) begin
                at = k;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int at, pulses, code, rl, seed;
        rst_n = 1'b0; tick = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        seed = int'($urandom(32'd20240611));
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R9 reset values
        rd(5'h00, v); check("R9 ctl read", v, 0);
        rd(5'h04, v); check("R9 psc reset", v, 0);
        rd(5'h08, v); check("R9 reload reset", v, 32'hFFF);
        rd(5'h10, v); check("R9 window reset", v, 32'hFFF);
        rd(5'h0C, v); check("R9 status reset", v, 0);
        rd(5'h14, v); check("R9 unmapped read", v, 0);
        check("R9 no request", {31'b0, req}, 0);

        // R3 idle: refresh before start never raises a request
        wr(5'h00, 32'hAAAA);
        pulses = 0;
        for (int k = 0; k < 300; k++) begin
            if (req) pulses++;
            @(negedge clk);
        end
        check("R3 idle refresh no request", pulses, 0);

        // R1 locked writes ignored
        wr(5'h04, 32'd3); idle(4);
        rd(5'h0C, v); check("R1 locked status", v, 0);
        rd(5'h04, v); check("R1 locked psc value", v, 0);
        wr(5'h00, 32'h5555); wr(5'h00, 32'h1234); wr(5'h08, 32'd7);
        rd(5'h0C, v); check("R1 relock by other key status", v, 0);
        idle(4); rd(5'h08, v); check("R1 relock by other key value", v, 32'hFFF);
        wr(5'h00, 32'h5555); wr(5'h00, 32'h0000); wr(5'h10, 32'd7);
        rd(5'h0C, v); check("R1 relock by zero status", v, 0);
        rd(5'h10, v); check("R1 relock by zero value", v, 32'hFFF);

        // R2 busy flag timing and delayed effect
        wr(5'h00, 32'h5555); wr(5'h08, 32'd5);
        rd(5'h0C, v); check("R2 reload busy set", v, 32'h2);
        rd(5'h08, v); check("R2 old value while busy", v, 32'hFFF);
        idle(2);
        rd(5'h0C, v); check("R2 reload busy held", v, 32'h2);
        idle(1);
        rd(5'h0C, v); check("R2 reload busy cleared", v, 0);
        rd(5'h08, v); check("R2 new value after busy", v, 32'd5);
        // R1 unlock persists after a config write
        wr(5'h04, 32'd1);
        rd(5'h0C, v); check("R1 still open psc busy", v, 32'h1);
        idle(3);
        rd(5'h04, v); check("R1 still open psc value", v, 32'd1);
        cfg(5'h04, 32'd0);

        // R3 R5 R7 start, then attempt to stop
        wr(5'h00, 32'hCCCC);
        wr(5'h00, 32'h0000);
        wait_req(100, at); check("R5 R7 first timeout", at, 5*4 - 1);
        @(negedge clk); check("R5 single cycle pulse", {31'b0, req}, 0);
        wait_req(100, at); check("R5 R7 continues after expiry", at, 5*4 - 1);

        // R4 R6 random codes and reloads
        for (int i = 0; i < 8; i++) begin
            code = int'($urandom_range(3, 0));
            rl   = int'($urandom_range(24, 1));
            cfg(5'h04, code);
            cfg(5'h08, rl);
            wr(5'h00, 32'hAAAA);
            wait_req(rl*ratio(code) + 8, at);
            check("R4 R6 random timeout", at, rl*ratio(code));
        end

        // R4 top code and clamped code
        cfg(5'h04, 32'd6); cfg(5'h08, 32'd1);
        wr(5'h00, 32'hAAAA);
        wait_req(600, at); check("R4 code 6 ratio 256", at, 256);
        cfg(5'h04, 32'd7); cfg(5'h08, 32'd2);
        wr(5'h00, 32'hAAAA);
        wait_req(600, at); check("R4 code 7 clamps to 256", at, 512);

        // R8 window check
        cfg(5'h04, 32'd0); cfg(5'h08, 32'd10);
        wr(5'h00, 32'hAAAA);
        wr(5'h00, 32'hAAAA);
        check("R8 max window disables check", {31'b0, req}, 0);
        cfg(5'h10, 32'd4);
        wr(5'h00, 32'hAAAA);
        check("R8 early refresh", {31'b0, req}, 1);
        idle(4); wr(5'h00, 32'hAAAA);
        check("R8 count 9 above window", {31'b0, req}, 1);
        idle(21); wr(5'h00, 32'hAAAA);
        check("R8 count 5 above window", {31'b0, req}, 1);
        idle(25); wr(5'h00, 32'hAAAA);
        check("R8 count equal window", {31'b0, req}, 0);
        idle(29); wr(5'h00, 32'hAAAA);
        check("R8 count below window", {31'b0, req}, 0);

        if (seed == 0) idle(1);
        summary();
        $finish;
    end
endmodule